// File: doc/BRIEF.md
# Out-of-Band Transmit Completion Timer

This block paces out-of-band signalling on a serial storage link. An OOB controller hands it a send request that names the sequence (reset or wake signalling) and the link generation currently in use. The block starts counting cycles toward a terminal count that depends on both the sequence and the generation. When the count runs out, the block produces its own completion strobe and does not wait for the transceiver to report.

The transceiver's own "finished" indication is only a hint. It can end the current request early, but only when it rises while that request is in flight. A level that was already high when the request was accepted is treated as left over from the previous sequence. The usual case is a reset sequence whose completion is still asserted when the wake sequence begins. Such a level is masked until it has been seen low. The transceiver strobe is never simply ORed into the output.

The block also drives a constant select that places the transceiver's transmit electrical-idle control in its clock-synchronous mode.

Top module: `oob_cmpl_timer`

## Requirements
- R1: After reset, `req_ready` is 1, and `busy` and `done_pulse` are both 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle, `busy` is 1 and `req_ready` is 0. Requests presented while busy change neither the timing nor the result of the request in progress.
- R3: With no qualified transceiver strobe, `done_pulse` is high in the cycle that starts exactly L rising edges after the accepting edge. L comes from a parameter table indexed by generation and sequence type. Sequence code 0 is reset signalling and code 1 is wake signalling. Generation codes 0, 1 and 2 select the first, second and third generation.
- R4: Generation code 3 uses the third-generation entries when the parameter that treats code 3 as the top generation is set (the default). Otherwise it uses the first-generation entries.
- R5: `done_pulse` lasts exactly one cycle. `busy` falls on the same edge that raises `done_pulse`, so a new request can be accepted on the very next edge.
- R6: A qualified transceiver strobe sampled high at edge k after acceptance, with k < L, ends the request early: `done_pulse` is high in the cycle after edge k.
- R7: If `xcvr_done` is high on the accepting edge, it is ignored until it has been sampled low while busy. A level held high for the whole request leaves the completion time at L.
- R8: `xcvr_done` pulses while the block is idle produce no `done_pulse` and do not shorten the next request.
- R9: `tx_idle_mode` is constantly 0, the code that selects synchronous electrical-idle control.
- R10: Asynchronous reset during a request drops `busy` at once and clears the counter. No completion strobe from the aborted request ever appears, and the next request runs its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Send request present |
| req_seq | input | 1 | Sequence type: 0 reset, 1 wake |
| req_gen | input | 2 | Link generation code |
| req_ready | output | 1 | Block idle, request can be taken |
| xcvr_done | input | 1 | Raw finished indication from the transceiver |
| done_pulse | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Request in progress |
| tx_idle_mode | output | 1 | Electrical-idle control mode select (0 = synchronous) |

## Verification
The bench goes after the stale-strobe case: the transceiver indication is held high across acceptance, sometimes for the whole request and sometimes until a later genuine pulse. A design that trusted any high level would finish one cycle after acceptance. It also checks each table entry and the reserved generation code, where an off-by-one in the counter or a wrong index would shift the strobe or pick the wrong sequence's length. Other targets are back-to-back requests, requests presented while busy, idle-time strobes and a reset in mid-request. A design that latched requests while busy, kept a stale arm flag, or let a pending strobe out after reset would emit an early, extra or missing `done_pulse`.

// File: rtl/oob_tmo_pkg.sv
package oob_tmo_pkg;

   typedef enum logic {
      SEQ_RESET = 1'b0,
      SEQ_WAKE  = 1'b1
   } oob_seq_e;

   typedef enum logic [1:0] {
      GEN_ONE   = 2'd0,
      GEN_TWO   = 2'd1,
      GEN_THREE = 2'd2,
      GEN_RSVD  = 2'd3
   } link_gen_e;

   // Transmit electrical-idle control mode code for clock-synchronous operation
   localparam logic IDLE_CTRL_SYNC = 1'b0;

   // Table entries: {generation, sequence}
   localparam int unsigned TBL_ENTRIES = 8;

   function automatic int unsigned max2(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/oob_tmo_limit_sel.sv
module oob_tmo_limit_sel
   import oob_tmo_pkg::*;
#(
   parameter int unsigned CYC_RST_G1   = 1200,
   parameter int unsigned CYC_RST_G2   = 2400,
   parameter int unsigned CYC_RST_G3   = 4800,
   parameter int unsigned CYC_WAKE_G1  = 600,
   parameter int unsigned CYC_WAKE_G2  = 1200,
   parameter int unsigned CYC_WAKE_G3  = 2400,
   parameter bit          RSVD_AS_GEN3 = 1'b1,
   parameter int unsigned CNT_W        = 13
) (
   input  logic [1:0]       gen,
   input  logic             seq,
   output logic [CNT_W-1:0] limit
);

   function automatic int unsigned entry_len(int unsigned g, int unsigned s);
      case (g)
         0:       return (s != 0) ? CYC_WAKE_G1 : CYC_RST_G1;
         1:       return (s != 0) ? CYC_WAKE_G2 : CYC_RST_G2;
         default: return (s != 0) ? CYC_WAKE_G3 : CYC_RST_G3;
      endcase
   endfunction

   logic [CNT_W-1:0] len_tbl [TBL_ENTRIES];
   logic [1:0]       eff_gen;

   for (genvar e = 0; e < TBL_ENTRIES; e++) begin : g_tbl
      assign len_tbl[e] = CNT_W'(entry_len(e / 2, e % 2));
   end

   if (RSVD_AS_GEN3) begin : g_rsvd_top
      assign eff_gen = (gen == GEN_RSVD) ? GEN_THREE : gen;
   end else begin : g_rsvd_low
      assign eff_gen = (gen == GEN_RSVD) ? GEN_ONE : gen;
   end

   assign limit = len_tbl[{eff_gen, seq}];

   always_comb begin
      AST_LIMIT_FLOOR: assert (limit >= CNT_W'(2)) else $error("terminal count below 2"); // R3
   end

endmodule

// File: rtl/oob_tmo_counter.sv
module oob_tmo_counter #(
   parameter int unsigned CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic             stop,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (start) begin
         cnt_q <= '0;
         lim_q <= limit;
      end else if (stop) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire = run && (cnt_q == lim_q - 1'b1);

   AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < lim_q)) else $error("counter passed terminal count"); // R3

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt_q == '0)) else $error("counter not cleared on start"); // R10

endmodule

// File: rtl/oob_tmo_qualify.sv
module oob_tmo_qualify (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic busy,
   input  logic xcvr_done,
   output logic hit
);

   // arm_q: the raw strobe has been seen low since the request began
   logic arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
      end else if (start) begin
         arm_q <= !xcvr_done;
      end else if (!busy) begin
         arm_q <= 1'b0;
      end else if (!xcvr_done) begin
         arm_q <= 1'b1;
      end
   end

   assign hit = busy && arm_q && xcvr_done;

   AST_STALE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (start && xcvr_done) |=> !hit) else $error("stale strobe accepted"); // R7

   AST_HELD_LEVEL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !arm_q && xcvr_done) |=> !hit) else $error("held level accepted"); // R7

endmodule

// File: rtl/oob_cmpl_timer.sv
module oob_cmpl_timer
   import oob_tmo_pkg::*;
#(
   parameter int unsigned CYC_RST_G1   = 1200,
   parameter int unsigned CYC_RST_G2   = 2400,
   parameter int unsigned CYC_RST_G3   = 4800,
   parameter int unsigned CYC_WAKE_G1  = 600,
   parameter int unsigned CYC_WAKE_G2  = 1200,
   parameter int unsigned CYC_WAKE_G3  = 2400,
   parameter bit          RSVD_AS_GEN3 = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_seq,
   input  logic [1:0] req_gen,
   output logic       req_ready,
   input  logic       xcvr_done,
   output logic       done_pulse,
   output logic       busy,
   output logic       tx_idle_mode
);

   localparam int unsigned CNT_MAX = max2(max2(max2(CYC_RST_G1, CYC_RST_G2), max2(CYC_RST_G3, CYC_WAKE_G1)),
                                          max2(CYC_WAKE_G2, CYC_WAKE_G3));
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   if (CYC_RST_G1 < 2 || CYC_RST_G2 < 2 || CYC_RST_G3 < 2 ||
       CYC_WAKE_G1 < 2 || CYC_WAKE_G2 < 2 || CYC_WAKE_G3 < 2) begin : g_bad_len
      $error("every terminal count must be at least 2 cycles");
   end

   logic [CNT_W-1:0] limit;
   logic             accept;
   logic             expire;
   logic             hit;
   logic             finish;
   logic             busy_q;
   logic             done_q;

   assign accept = req_valid && !busy_q;
   assign finish = expire || hit;

   oob_tmo_limit_sel #(
      .CYC_RST_G1  (CYC_RST_G1),
      .CYC_RST_G2  (CYC_RST_G2),
      .CYC_RST_G3  (CYC_RST_G3),
      .CYC_WAKE_G1 (CYC_WAKE_G1),
      .CYC_WAKE_G2 (CYC_WAKE_G2),
      .CYC_WAKE_G3 (CYC_WAKE_G3),
      .RSVD_AS_GEN3(RSVD_AS_GEN3),
      .CNT_W       (CNT_W)
   ) i_limit_sel (
      .gen  (req_gen),
      .seq  (req_seq),
      .limit(limit)
   );

   oob_tmo_counter #(
      .CNT_W(CNT_W)
   ) i_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .run   (busy_q),
      .stop  (finish),
      .limit (limit),
      .expire(expire)
   );

   oob_tmo_qualify i_qualify (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .busy     (busy_q),
      .xcvr_done(xcvr_done),
      .hit      (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= finish;
         if (accept) begin
            busy_q <= 1'b1;
         end else if (finish) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy         = busy_q;
   assign req_ready    = !busy_q;
   assign done_pulse   = done_q;
   assign tx_idle_mode = IDLE_CTRL_SYNC;

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse) else $error("completion strobe longer than one cycle"); // R5

   AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> !busy) else $error("busy still set with completion"); // R5

   AST_DONE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> $past(busy)) else $error("completion without a request"); // R8

   AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (busy && !done_pulse)) else $error("accepted request not busy"); // R2

endmodule

// File: tb/test_oob_cmpl_timer.sv
module test_oob_cmpl_timer;

   localparam int CLK_PERIOD = 10;
   localparam int TB_RST_G1  = 40;
   localparam int TB_RST_G2  = 60;
   localparam int TB_RST_G3  = 90;
   localparam int TB_WAKE_G1 = 20;
   localparam int TB_WAKE_G2 = 30;
   localparam int TB_WAKE_G3 = 45;

   logic       clk       = 1'b0;
   logic       rst_n     = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_seq   = 1'b0;
   logic [1:0] req_gen   = 2'd0;
   logic       xcvr_done = 1'b0;
   logic       req_ready;
   logic       done_pulse;
   logic       busy;
   logic       tx_idle_mode;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   oob_cmpl_timer #(
      .CYC_RST_G1  (TB_RST_G1),
      .CYC_RST_G2  (TB_RST_G2),
      .CYC_RST_G3  (TB_RST_G3),
      .CYC_WAKE_G1 (TB_WAKE_G1),
      .CYC_WAKE_G2 (TB_WAKE_G2),
      .CYC_WAKE_G3 (TB_WAKE_G3),
      .RSVD_AS_GEN3(1'b1)
   ) i_oob_cmpl_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_seq     (req_seq),
      .req_gen     (req_gen),
      .req_ready   (req_ready),
      .xcvr_done   (xcvr_done),
      .done_pulse  (done_pulse),
      .busy        (busy),
      .tx_idle_mode(tx_idle_mode)
   );

   task automatic chk(string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   // Expected terminal count from R3 / R4 (code 3 -> third generation)
   function automatic int exp_len(int g, int s);
      case (g)
         0:       return (s != 0) ? TB_WAKE_G1 : TB_RST_G1;
         1:       return (s != 0) ? TB_WAKE_G2 : TB_RST_G2;
         default: return (s != 0) ? TB_WAKE_G3 : TB_RST_G3;
      endcase
   endfunction

   // start_high: xcvr_done high at the accepting edge, held until edge m (m == 0: whole request)
   // p: edge index of a single genuine pulse (0: none)
   task automatic run_req(int g, int s, bit start_high, int m, int p, bit noise, string tag);
      int len = exp_len(g, s);
      int n   = (p > 0 && p < len) ? p : len;
      @(negedge clk);
      req_valid = 1'b1;
      req_gen   = 2'(g);
      req_seq   = 1'(s);
      xcvr_done = start_high;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " R2 busy after accept"}, busy, 1);
      chk({tag, " R2 ready low after accept"}, req_ready, 0);
      chk({tag, " R5 no strobe on accept cycle"}, done_pulse, 0);
      for (int k = 1; k <= n; k++) begin
         xcvr_done = (start_high && (m == 0 || k < m)) ? 1'b1 : (k == p);
         if (noise) begin
            req_valid = 1'($urandom % 2);
            req_gen   = 2'($urandom % 4);
            req_seq   = 1'($urandom % 2);
         end
         @(posedge clk);
         @(negedge clk);
         if (k == n) begin
            chk({tag, " done strobe at expected edge"}, done_pulse, 1);
            chk({tag, " R5 busy cleared with strobe"}, busy, 0);
            chk({tag, " R5 ready back with strobe"}, req_ready, 1);
         end else begin
            chk({tag, " no early strobe"}, done_pulse, 0);
         end
      end
      req_valid = 1'b0;
      xcvr_done = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 ready at reset", req_ready, 1);
      chk("R1 busy at reset", busy, 0);
      chk("R1 done at reset", done_pulse, 0);
      chk("R9 idle mode select", tx_idle_mode, 0);
      rst_n = 1'b1;

      // R3 / R4: every table entry, including reserved generation code
      for (int g = 0; g < 4; g++) begin
         for (int s = 0; s < 2; s++) begin
            run_req(g, s, 1'b0, 0, 0, 1'b0, (g == 3) ? "R4" : "R3");
         end
      end

      // R6: genuine early strobes
      run_req(1, 0, 1'b0, 0, 5, 1'b0, "R6 mid");
      run_req(0, 1, 1'b0, 0, 1, 1'b0, "R6 first edge");
      run_req(2, 1, 1'b0, 0, TB_WAKE_G3 - 1, 1'b0, "R6 last edge");

      // R7: stale level carried over from previous sequence
      run_req(0, 1, 1'b1, 0, 0, 1'b0, "R7 held whole request");
      run_req(1, 1, 1'b1, 3, 0, 1'b0, "R7 stale then quiet");
      run_req(2, 1, 1'b1, 4, 9, 1'b0, "R7 stale then real");

      // R2: requests while busy are ignored
      run_req(0, 0, 1'b0, 0, 0, 1'b1, "R2 noise");
      run_req(2, 1, 1'b0, 0, 0, 1'b1, "R2 noise");

      // R8: strobes while idle
      for (int k = 0; k < 6; k++) begin
         xcvr_done = 1'(k % 2);
         @(posedge clk);
         @(negedge clk);
         chk("R8 no strobe while idle", done_pulse, 0);
         chk("R8 stays idle", busy, 0);
      end
      xcvr_done = 1'b0;
      run_req(1, 0, 1'b0, 0, 0, 1'b0, "R8 after idle pulses");

      // R10: reset in the middle of a request
      @(negedge clk);
      req_valid = 1'b1;
      req_gen   = 2'd0;
      req_seq   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b0;
      #1;
      chk("R10 busy drops at reset", busy, 0);
      chk("R10 ready at reset", req_ready, 1);
      chk("R10 no strobe at reset", done_pulse, 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < TB_WAKE_G1 + 5; k++) begin
         @(negedge clk);
         chk("R10 no strobe from aborted request", done_pulse, 0);
      end
      run_req(0, 1, 1'b0, 0, 0, 1'b0, "R10 full length after reset");

      // Constrained random mix
      for (int i = 0; i < 40; i++) begin
         int g    = $urandom % 4;
         int s    = $urandom % 2;
         int scen = $urandom % 3;
         int len  = exp_len(g, s);
         bit nz   = 1'($urandom % 2);
         case (scen)
            0: run_req(g, s, 1'b0, 0, 0, nz, "R3 random");
            1: run_req(g, s, 1'b0, 0, 1 + int'($urandom % (len + 5)), nz, "R6 random");
            default: begin
               int m = 1 + int'($urandom % 5);
               run_req(g, s, 1'b1, m, m + 1 + int'($urandom % len), nz, "R7 random");
            end
         endcase
      end

      @(negedge clk);
      chk("R9 idle mode select at end", tx_idle_mode, 0);
      summary();
      $finish;
   end

endmodule